// File: doc/BRIEF.md
# First-Press Quiz Lockout Arbiter

This block settles who answers first in a quiz round with eight players. Every player has an active-low push button, and the players are numbered 1 to 8. After a reset the block waits. The first press it sees fixes that player's number as the round's result and raises a buzzer flag. The block then ignores every later press until the shared reset starts the next round.

The button lines are brought into the clock domain through a synchronizer chain. A button is accepted only once it has been seen released after reset, so a player who holds a button down through the reset cannot take the round by default. If several accepted presses reach the arbitration stage on the same clock edge, the highest player number wins. The result is given as a binary number, as a valid/buzzer flag and as an active-high seven-segment pattern. All outputs are registered.

Top module: `quiz_lockout_arbiter`

## Requirements
- R1: While `rst` is high, and in every cycle after it until a press is accepted, `winner` is 0, `winner_valid` and `buzzer` are 0, and `seg` shows the digit 0 (7'h3F).
- R2: Bit i of `btn_n` belongs to player i+1. A 1 on that bit means released and a 0 means pressed. A press accepted while idle loads `winner` with i+1 and raises `winner_valid`.
- R3: The outputs respond on the third rising clock edge after a press is applied. Two synchronizer edges come first, then the capture edge. At the second edge the outputs still show the idle state.
- R4: When presses from several players reach the capture edge together, `winner` takes the largest player number among them.
- R5: Once a winner is held, new presses on any input leave `winner` and `seg` unchanged, including presses from higher-numbered players.
- R6: `buzzer` equals `winner_valid`. It stays high for as long as a winner is held, and releasing the buttons does not clear it; only `rst` does.
- R7: `seg` is active high with bit 6 = g, bit 5 = f, bit 4 = e, bit 3 = d, bit 2 = c, bit 1 = b and bit 0 = a. Digit codes: 0 = 3F, 1 = 06, 2 = 5B, 3 = 4F, 4 = 66, 5 = 6D, 6 = 7D, 7 = 07, 8 = 7F.
- R8: A button that is held while `rst` is high cannot win until it has been released for at least three clock edges after reset and pressed again.
- R9: Raising `rst` (synchronous, active high) during a held round clears the result on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new round |
| btn_n | input | 8 | Player buttons, active low; bit i is player i+1 |
| winner | output | 4 | Number of the captured player, 0 while idle |
| winner_valid | output | 1 | High while a winner is held |
| buzzer | output | 1 | Buzzer drive, same as winner_valid |
| seg | output | 7 | Seven-segment pattern g..a, active high |

## Verification
Each press the bench drives on a falling edge has its expected result due exactly three rising edges later. The scoreboard stores that due cycle together with the expected number, flag and segment pattern, and the monitor compares only on the falling edge of that cycle. An entry due one edge earlier confirms that the idle state still holds at the second edge. Reset checks are due one edge after `rst` is raised. For the lockout and held-button cases, the scoreboard schedules entries several cycles after the ignored press, so the outputs are seen to stay unchanged after the point where a wrong capture would already have appeared.

// File: rtl/quiz_pkg.sv
package quiz_pkg;

  localparam int SEG_W = 7;

  // Active-high pattern, bit 6 = g down to bit 0 = a.
  function automatic logic [SEG_W-1:0] seg_encode(input int unsigned value);
    logic [SEG_W-1:0] pat;
    case (value)
      0:       pat = 7'h3F;
      1:       pat = 7'h06;
      2:       pat = 7'h5B;
      3:       pat = 7'h4F;
      4:       pat = 7'h66;
      5:       pat = 7'h6D;
      6:       pat = 7'h7D;
      7:       pat = 7'h07;
      8:       pat = 7'h7F;
      9:       pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/qla_btn_sync.sv
module qla_btn_sync #(
  parameter int N_PLAYERS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_PLAYERS-1:0] btn_n,
  output logic [N_PLAYERS-1:0] press
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [N_PLAYERS-1:0] chain [SYNC_STAGES];
  logic [N_PLAYERS-1:0] armed;

  // Stages reset to "pressed" so a button held through reset never looks released.
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= btn_n;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  for (genvar p = 0; p < N_PLAYERS; p++) begin : g_arm
    always_ff @(posedge clk) begin
      if (rst)               armed[p] <= 1'b0;
      else if (chain[LAST][p]) armed[p] <= 1'b1;
    end
    assign press[p] = armed[p] & ~chain[LAST][p];
  end

endmodule

// File: rtl/qla_pick_lock.sv
module qla_pick_lock #(
  parameter int N_PLAYERS = 8,
  parameter int NUM_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_PLAYERS-1:0] press,
  output logic [NUM_W-1:0]     win_next,
  output logic [NUM_W-1:0]     win_q,
  output logic                 held_q
);

  logic [NUM_W-1:0] pick;
  logic             any_press;

  // Ascending scan: the highest pressed index is written last and wins.
  always_comb begin
    pick = '0;
    for (int i = 0; i < N_PLAYERS; i++) begin
      if (press[i]) pick = NUM_W'(i + 1);
    end
  end

  assign any_press = |press;

  always_comb begin
    if (rst)                       win_next = '0;
    else if (!held_q && any_press) win_next = pick;
    else                           win_next = win_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      held_q <= 1'b0;
    end else if (!held_q && any_press) begin
      win_q  <= pick;
      held_q <= 1'b1;
    end
  end

endmodule

// File: rtl/qla_seg_out.sv
module qla_seg_out #(
  parameter int NUM_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_W-1:0]           win_next,
  output logic [quiz_pkg::SEG_W-1:0] seg_q
);

  always_ff @(posedge clk) begin
    if (rst) seg_q <= quiz_pkg::seg_encode(0);
    else     seg_q <= quiz_pkg::seg_encode(int'(win_next));
  end

endmodule

// File: rtl/quiz_lockout_arbiter.sv
module quiz_lockout_arbiter #(
  parameter int N_PLAYERS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_W      = $clog2(N_PLAYERS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PLAYERS-1:0]       btn_n,
  output logic [NUM_W-1:0]           winner,
  output logic                       winner_valid,
  output logic                       buzzer,
  output logic [quiz_pkg::SEG_W-1:0] seg
);

  logic [N_PLAYERS-1:0] press;
  logic [NUM_W-1:0]     win_next;
  logic [NUM_W-1:0]     win_q;
  logic                 held_q;

  qla_btn_sync #(
    .N_PLAYERS  (N_PLAYERS),
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk  (clk),
    .rst  (rst),
    .btn_n(btn_n),
    .press(press)
  );

  qla_pick_lock #(
    .N_PLAYERS(N_PLAYERS),
    .NUM_W    (NUM_W)
  ) lock_i (
    .clk     (clk),
    .rst     (rst),
    .press   (press),
    .win_next(win_next),
    .win_q   (win_q),
    .held_q  (held_q)
  );

  qla_seg_out #(
    .NUM_W(NUM_W)
  ) seg_i (
    .clk     (clk),
    .rst     (rst),
    .win_next(win_next),
    .seg_q   (seg)
  );

  assign winner       = win_q;
  assign winner_valid = held_q;
  assign buzzer       = held_q;

endmodule

// File: rtl/quiz_lockout_arbiter_chk.sv
module quiz_lockout_arbiter_chk #(
  parameter int N_PLAYERS = 8,
  parameter int NUM_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [N_PLAYERS-1:0]       btn_n,
  input logic [NUM_W-1:0]           winner,
  input logic                       winner_valid,
  input logic                       buzzer,
  input logic [quiz_pkg::SEG_W-1:0] seg
);

  // R1: idle means no number and the zero digit
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !winner_valid |-> (winner == '0 && seg == 7'h3F));

  // R2: a held number always lies in 1..N
  p_valid_range_r2: assert property (@(posedge clk) disable iff (rst)
    winner_valid |-> (winner >= NUM_W'(1) && winner <= NUM_W'(N_PLAYERS)));

  // R2/R3: a new winner's button was low at the input two edges before capture
  p_cause_press_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(winner_valid) |-> ($past(btn_n, 2) & (N_PLAYERS'(1) << (winner - NUM_W'(1)))) == '0);

  // R5/R6: a held result never moves and never drops without reset
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (rst)
    winner_valid |=> (winner_valid && $stable(winner) && $stable(seg)));

  // R6: buzzer follows the valid flag
  p_buzz_follow_r6: assert property (@(posedge clk) disable iff (rst)
    buzzer == winner_valid);

  // R9: reset clears the round on the next edge
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!winner_valid && !buzzer && winner == '0 && seg == 7'h3F));

endmodule

bind quiz_lockout_arbiter quiz_lockout_arbiter_chk #(
  .N_PLAYERS(N_PLAYERS),
  .NUM_W    (NUM_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .btn_n       (btn_n),
  .winner      (winner),
  .winner_valid(winner_valid),
  .buzzer      (buzzer),
  .seg         (seg)
);

// File: tb/quiz_lockout_arbiter_tb_top.sv
module quiz_lockout_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 8;

  typedef struct {
    int         due;
    logic [3:0] win;
    logic       vld;
    logic [6:0] seg;
    string      req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] btn_n = '1;
  logic [3:0]    winner;
  logic          winner_valid;
  logic          buzzer;
  logic [6:0]    seg;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quiz_lockout_arbiter dut_i (
    .clk         (clk),
    .rst         (rst),
    .btn_n       (btn_n),
    .winner      (winner),
    .winner_valid(winner_valid),
    .buzzer      (buzzer),
    .seg         (seg)
  );

  // R7 table, bit 6 = g .. bit 0 = a
  function automatic logic [6:0] seg_ref(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B;
      3: return 7'h4F; 4: return 7'h66; 5: return 7'h6D;
      6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic expect_in(input int dly, input int w, input string req);
    exp_t e;
    e.due = cyc + dly;
    e.win = 4'(w);
    e.vld = (w != 0);
    e.seg = seg_ref(w);
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [NP-1:0] held_n);
    @(negedge clk);
    btn_n = held_n;
    rst = 1'b1;
    expect_in(1, 0, "R9");
    idle(2);
    rst = 1'b0;
    expect_in(1, 0, "R1");
    idle(5);
  endtask

  // Monitor: compares on falling edges when an entry falls due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.due != cyc || winner !== e.win || winner_valid !== e.vld ||
          buzzer !== e.vld || seg !== e.seg) begin
        failures++;
        $display("FAIL %s cyc=%0d actual win=%0d vld=%b buz=%b seg=%h expected win=%0d vld=%b seg=%h",
                 e.req, cyc, winner, winner_valid, buzzer, seg, e.win, e.vld, e.seg);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    btn_n = '1;
    rst = 1'b1;
    idle(3);
    expect_in(0, 0, "R1");
    idle(1);
    rst = 1'b0;
    idle(5);
    expect_in(0, 0, "R1");
    idle(1);

    // R2/R3: player 3 presses; idle at +2, result at +3
    btn_n = 8'b1111_1011;
    expect_in(2, 0, "R3");
    expect_in(3, 3, "R2");
    idle(5);
    // R6: releasing keeps the result and buzzer
    btn_n = '1;
    expect_in(4, 3, "R6");
    idle(5);
    // R5: later press from player 8 is ignored
    btn_n = 8'b0111_1111;
    expect_in(3, 3, "R5");
    expect_in(6, 3, "R5");
    idle(8);
    btn_n = '1;

    // R9: reset mid-round clears; R4: players 2 and 6 together
    do_reset('1);
    btn_n = 8'b1101_1101;
    expect_in(3, 6, "R4");
    idle(6);
    btn_n = '1;

    // R8: player 5 held through reset cannot win
    do_reset(8'b1110_1111);
    expect_in(4, 0, "R8");
    idle(6);
    btn_n = '1;
    idle(4);
    btn_n = 8'b1111_1110;
    expect_in(3, 1, "R8");
    idle(6);
    btn_n = '1;

    // R2/R7: each player alone, number and segment pattern
    for (int p = 1; p <= NP; p++) begin
      do_reset('1);
      btn_n = ~(NP'(1) << (p - 1));
      expect_in(3, p, "R7");
      idle(5);
      btn_n = '1;
    end

    idle(3);
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule